// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the timing strobes for the multiplexed external bus of an 8051-style microcontroller. It runs on the oscillator clock and splits time into machine cycles of twelve oscillator periods, numbered as phases 0 to 11. From per-cycle attributes it drives three outputs. The first is the address-latch strobe `ale`. The second is the active-low program-store read strobe `psen_n`. The third is the value on the high-order address port `p2_out`. The attributes are: executing from external code, an external data access and its pointer width, a code-table read, and a software ALE-off bit.

The attributes are sampled once per machine cycle, on the clock edge that closes phase 11, and they hold for the whole cycle that follows. The reset input is filtered: it acts only after it has been high for two whole machine cycles.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: The internal reset takes effect on the clock edge after `rst` has been sampled high on 24 consecutive rising edges (two machine cycles). A shorter high pulse leaves the strobe pattern and the phase count undisturbed.
- R2: While reset is in effect, `ale` is 0, `psen_n` is 1 and `p2_out` equals `p2_sfr`. The first rising edge after reset is released holds phase 11, and the next edge starts phase 0 with freshly sampled attributes.
- R3: In a normal cycle (no external data access, ALE not held off), `ale` is 1 during phases 0, 1, 6 and 7 and 0 elsewhere. That gives two pulses per twelve clocks.
- R4: In a cycle with `xdata_acc`=1, the first ALE pulse (phases 0 and 1) is omitted and the second one (phases 6 and 7) stays.
- R5: With `ext_code`=1 and no data access, `psen_n` is 0 during phases 3 to 5 and 9 to 11 and 1 elsewhere. ALE and PSEN never overlap.
- R6: In a cycle with `xdata_acc`=1, `psen_n` stays 1 for all twelve phases.
- R7: With `ext_code`=0, `psen_n` stays 1 throughout.
- R8: With `ale_off`=1, `ext_code`=0, `xdata_acc`=0 and `code_tbl_rd`=0, `ale` rests at 1 for the whole cycle.
- R9: With `ale_off`=1 and `ext_code`=0, a cycle with `xdata_acc`=1 or `code_tbl_rd`=1 gets the normal ALE pattern of R3/R4.
- R10: With `ext_code`=1, `ale_off` has no effect on `ale`.
- R11: In an external fetch cycle (`ext_code`=1, `xdata_acc`=0), and in a data cycle with `xdata_wide`=1, `p2_out` equals `addr_hi`.
- R12: In a data cycle with `xdata_wide`=0, `p2_out` equals `p2_sfr`. It also equals `p2_sfr` in an internal-code cycle with no data access.
- R13: Flag inputs that change during phases 0 to 11 do not affect the current cycle. They take effect only in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Raw reset input, active high, filtered over two machine cycles |
| ext_code | input | 1 | Device executes from external program memory |
| xdata_acc | input | 1 | Current cycle accesses external data memory |
| xdata_wide | input | 1 | External data access uses a 16-bit pointer (0 selects an 8-bit pointer) |
| code_tbl_rd | input | 1 | Current cycle is a code-table read |
| ale_off | input | 1 | Software ALE-off control bit |
| addr_hi | input | PORT_W | Upper address byte |
| p2_sfr | input | PORT_W | Port-2 register contents |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| p2_out | output | PORT_W | High-order address port value |

## Verification
Flag inputs count only at the rising edge that closes phase 11. `ale` and `psen_n` are registered, so the level for phase p appears right after the edge that enters phase p. `p2_out` follows `addr_hi` or `p2_sfr` with no delay, with the choice made by the latched attributes. The bench keeps its own phase counter, advanced on each falling edge. It latches its copy of the flags as they stood before the edge that wraps the phase to 0 and checks all three outputs at every falling edge against that copy. The reset checks wait for the 25th edge of a long pulse and for the release edge.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    localparam int MC_LEN  = 12;
    localparam int PH_W    = $clog2(MC_LEN);
    localparam int ALE_A0  = 0;
    localparam int ALE_B0  = MC_LEN / 2;
    localparam int ALE_W   = 2;
    localparam int PSEN_A0 = 3;
    localparam int PSEN_B0 = PSEN_A0 + MC_LEN / 2;
    localparam int PSEN_W  = 3;

    typedef logic [PH_W-1:0] phase_t;
    localparam phase_t PH_LAST = phase_t'(MC_LEN - 1);

    typedef struct packed {
        logic ext_code;
        logic dcyc;
        logic d16;
        logic movc;
        logic ale_dis;
    } cyc_attr_t;

    localparam cyc_attr_t ATTR_RST = '0;

    typedef enum logic {HI_SFR = 1'b0, HI_ADDR = 1'b1} hi_src_e;

    function automatic logic in_win(phase_t p, int start, int width);
        return (int'(p) >= start) && (int'(p) < start + width);
    endfunction

    function automatic logic ale_level(phase_t p, cyc_attr_t a);
        if (a.ale_dis && !a.ext_code && !a.dcyc && !a.movc)
            return 1'b1;
        return (in_win(p, ALE_A0, ALE_W) && !a.dcyc) || in_win(p, ALE_B0, ALE_W);
    endfunction

    function automatic logic psen_level_n(phase_t p, cyc_attr_t a);
        return !(a.ext_code && !a.dcyc &&
                 (in_win(p, PSEN_A0, PSEN_W) || in_win(p, PSEN_B0, PSEN_W)));
    endfunction

    function automatic hi_src_e hi_select(cyc_attr_t a);
        if (a.dcyc && !a.d16) return HI_SFR;
        if (a.ext_code || a.dcyc) return HI_ADDR;
        return HI_SFR;
    endfunction

endpackage

// File: rtl/ebs_rst_filter.sv
module ebs_rst_filter #(
    parameter int HOLD = 24
) (
    input  logic clk,
    input  logic rst_in,
    output logic sys_rst
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_in)
            run_cnt <= '0;
        else if (run_cnt != LIMIT)
            run_cnt <= run_cnt + 1'b1;
    end

    assign sys_rst = (run_cnt == LIMIT);
endmodule

// File: rtl/ebs_phase_gen.sv
module ebs_phase_gen
    import ebs_pkg::*;
(
    input  logic   clk,
    input  logic   sys_rst,
    output phase_t phase_q,
    output phase_t phase_nx,
    output logic   wrap
);
    assign wrap     = (phase_q == PH_LAST);
    assign phase_nx = wrap ? '0 : phase_q + 1'b1;

    always_ff @(posedge clk) begin
        if (sys_rst) phase_q <= PH_LAST;
        else         phase_q <= phase_nx;
    end
endmodule

// File: rtl/ebs_strobe_dec.sv
module ebs_strobe_dec
    import ebs_pkg::*;
(
    input  logic      clk,
    input  logic      sys_rst,
    input  logic      wrap,
    input  phase_t    phase_nx,
    input  cyc_attr_t attr_in,
    output cyc_attr_t attr_q,
    output logic      ale_q,
    output logic      psen_n_q
);
    cyc_attr_t attr_nx;

    assign attr_nx = wrap ? attr_in : attr_q;

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            attr_q   <= ATTR_RST;
            ale_q    <= 1'b0;
            psen_n_q <= 1'b1;
        end else begin
            attr_q   <= attr_nx;
            ale_q    <= ale_level(phase_nx, attr_nx);
            psen_n_q <= psen_level_n(phase_nx, attr_nx);
        end
    end
endmodule

// File: rtl/ebs_addr_mux.sv
module ebs_addr_mux
    import ebs_pkg::*;
#(
    parameter int W = 8
) (
    input  hi_src_e      sel,
    input  logic [W-1:0] addr_hi,
    input  logic [W-1:0] p2_sfr,
    output logic [W-1:0] p2_out
);
    always_comb begin
        unique case (sel)
            HI_ADDR: p2_out = addr_hi;
            default: p2_out = p2_sfr;
        endcase
    end
endmodule

// File: rtl/ext_bus_strobe_seq.sv
module ext_bus_strobe_seq
    import ebs_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int RST_MC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_code,
    input  logic              xdata_acc,
    input  logic              xdata_wide,
    input  logic              code_tbl_rd,
    input  logic              ale_off,
    input  logic [PORT_W-1:0] addr_hi,
    input  logic [PORT_W-1:0] p2_sfr,
    output logic              ale,
    output logic              psen_n,
    output logic [PORT_W-1:0] p2_out
);
    localparam int HOLD_CYC = RST_MC * MC_LEN;

    logic      sys_rst;
    logic      wrap;
    phase_t    phase_q;
    phase_t    phase_nx;
    cyc_attr_t live_attr;
    cyc_attr_t cur_attr;

    assign live_attr = '{ext_code: ext_code, dcyc: xdata_acc, d16: xdata_wide,
                         movc: code_tbl_rd, ale_dis: ale_off};

    ebs_rst_filter #(.HOLD(HOLD_CYC)) u_rst (
        .clk    (clk),
        .rst_in (rst),
        .sys_rst(sys_rst)
    );

    ebs_phase_gen u_phase (
        .clk     (clk),
        .sys_rst (sys_rst),
        .phase_q (phase_q),
        .phase_nx(phase_nx),
        .wrap    (wrap)
    );

    ebs_strobe_dec u_strobe (
        .clk     (clk),
        .sys_rst (sys_rst),
        .wrap    (wrap),
        .phase_nx(phase_nx),
        .attr_in (live_attr),
        .attr_q  (cur_attr),
        .ale_q   (ale),
        .psen_n_q(psen_n)
    );

    ebs_addr_mux #(.W(PORT_W)) u_mux (
        .sel    (hi_select(cur_attr)),
        .addr_hi(addr_hi),
        .p2_sfr (p2_sfr),
        .p2_out (p2_out)
    );
endmodule

// File: rtl/ebs_checker.sv
module ebs_checker
    import ebs_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         sys_rst,
    input logic         wrap,
    input cyc_attr_t    attr,
    input logic         ale,
    input logic         psen_n,
    input logic [W-1:0] addr_hi,
    input logic [W-1:0] p2_sfr,
    input logic [W-1:0] p2_out
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (sys_rst) armed <= 1'b1;
    end

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!armed)
        sys_rst |=> (!ale && psen_n)); // R2
    AST_ALE_PAIR: assert property (@(posedge clk) disable iff (!armed || sys_rst)
        $rose(ale) |=> ale); // R3
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!armed || sys_rst)
        !(ale && !psen_n)); // R5
    AST_DATA_NO_PSEN: assert property (@(posedge clk) disable iff (!armed || sys_rst)
        attr.dcyc |-> psen_n); // R6
    AST_INT_NO_PSEN: assert property (@(posedge clk) disable iff (!armed || sys_rst)
        !attr.ext_code |-> psen_n); // R7
    AST_ALE_REST: assert property (@(posedge clk) disable iff (!armed || sys_rst)
        (attr.ale_dis && !attr.ext_code && !attr.dcyc && !attr.movc) |-> ale); // R8
    AST_P2_FETCH: assert property (@(posedge clk) disable iff (!armed || sys_rst)
        (attr.ext_code && (!attr.dcyc || attr.d16)) |-> (p2_out == addr_hi)); // R11
    AST_P2_NARROW: assert property (@(posedge clk) disable iff (!armed || sys_rst)
        (attr.dcyc && !attr.d16) |-> (p2_out == p2_sfr)); // R12
    AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!armed || sys_rst)
        !$past(wrap) |-> $stable(attr)); // R13
endmodule

bind ext_bus_strobe_seq ebs_checker #(.W(PORT_W)) u_chk (
    .clk    (clk),
    .sys_rst(sys_rst),
    .wrap   (wrap),
    .attr   (cur_attr),
    .ale    (ale),
    .psen_n (psen_n),
    .addr_hi(addr_hi),
    .p2_sfr (p2_sfr),
    .p2_out (p2_out)
);

// File: tb/ext_bus_strobe_seq_bench.sv
module ext_bus_strobe_seq_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       ext_code, xdata_acc, xdata_wide, code_tbl_rd, ale_off;
    logic [7:0] addr_hi, p2_sfr;
    logic       ale, psen_n;
    logic [7:0] p2_out;

    int         n_chk = 0;
    int         n_fail = 0;
    int         ph = 11;
    bit         chk_en = 0;
    bit         scr = 0;
    bit         done = 0;
    logic [4:0] lat = '0;   // {ext, data, wide, table, off}

    always #4 clk = ~clk;

    ext_bus_strobe_seq u_ext_bus_strobe_seq (
        .clk(clk), .rst(rst), .ext_code(ext_code), .xdata_acc(xdata_acc),
        .xdata_wide(xdata_wide), .code_tbl_rd(code_tbl_rd), .ale_off(ale_off),
        .addr_hi(addr_hi), .p2_sfr(p2_sfr), .ale(ale), .psen_n(psen_n), .p2_out(p2_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (phase %0d)", tag, act, exp, ph);
        end
    endtask

    task automatic set_flags(input logic [4:0] f);
        {ext_code, xdata_acc, xdata_wide, code_tbl_rd, ale_off} = f;
    endtask

    task automatic step(input string pre);
        logic [4:0] drv;
        logic       rest, e_ale, e_psn;
        logic [7:0] e_p2;
        string      t_ale, t_psn, t_p2;
        drv = {ext_code, xdata_acc, xdata_wide, code_tbl_rd, ale_off};
        @(negedge clk);
        ph = (ph + 1) % 12;
        if (ph == 0) lat = drv;
        if (chk_en) begin
            rest  = lat[0] && !lat[4] && !lat[3] && !lat[1];
            e_ale = rest ? 1'b1 : (((ph < 2) && !lat[3]) || (ph == 6) || (ph == 7));
            e_psn = !(lat[4] && !lat[3] && (((ph >= 3) && (ph <= 5)) || (ph >= 9)));
            e_p2  = (lat[3] && !lat[2]) ? p2_sfr : ((lat[4] || lat[3]) ? addr_hi : p2_sfr);
            t_ale = rest ? "R8" : (lat[4] && lat[0]) ? "R10" : lat[0] ? "R9" :
                    lat[3] ? "R4" : "R3";
            t_psn = !lat[4] ? "R7" : lat[3] ? "R6" : "R5";
            t_p2  = (lat[3] && !lat[2]) ? "R12" : (lat[4] || lat[3]) ? "R11" : "R12";
            chk({pre, scr ? "R13 " : "", t_ale, " ale"}, {7'b0, ale}, {7'b0, e_ale});
            chk({pre, scr ? "R13 " : "", t_psn, " psen_n"}, {7'b0, psen_n}, {7'b0, e_psn});
            chk({pre, scr ? "R13 " : "", t_p2, " p2_out"}, p2_out, e_p2);
        end
    endtask

    task automatic reset_vals(input string tag);
        chk({tag, " ale in reset"}, {7'b0, ale}, 8'h00);
        chk({tag, " psen_n in reset"}, {7'b0, psen_n}, 8'h01);
        chk({tag, " p2_out in reset"}, p2_out, p2_sfr);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 0;
        set_flags(5'b0);
        addr_hi = 8'hC3;
        p2_sfr  = 8'h5A;
        repeat (2) @(negedge clk);

        // R1 / R2: long reset pulse from power-up
        rst = 1;
        repeat (26) @(negedge clk);
        reset_vals("R1");
        rst = 0;
        @(negedge clk);
        reset_vals("R2");
        ph = 11;
        chk_en = 1;

        // Sweep all 32 flag combinations; R13 scramble after phase 2
        for (int i = 0; i < 32; i++) begin
            scr = 0;
            set_flags(i[4:0]);
            addr_hi = {3'b101, i[4:0]};
            p2_sfr  = {3'b010, i[4:0]};
            for (int p = 0; p < 12; p++) begin
                step("");
                if (ph == 2) begin
                    set_flags(~i[4:0]);
                    scr = 1;
                end
            end
        end
        scr = 0;

        // R1: short pulse of 20 clocks is ignored
        set_flags(5'b10000);
        addr_hi = 8'hE7;
        p2_sfr  = 8'h18;
        rst = 1;
        repeat (20) step("R1 ");
        rst = 0;
        repeat (24) step("R1 ");

        // R1: full-length pulse while running, then R2 release
        rst = 1;
        repeat (24) step("R1 ");
        @(negedge clk);
        reset_vals("R1");
        rst = 0;
        set_flags(5'b00001);
        @(negedge clk);
        reset_vals("R2");
        ph = 11;
        repeat (24) step("R2 ");

        summary();
        $finish;
    end
endmodule